// File: doc/BRIEF.md
# Two-Frame Responder Serial Transmitter

This block answers a trigger with a fixed reply of two asynchronous frames sent back to back on one serial line. The first frame carries an identification byte and the second carries a status byte. Each byte is taken from its own parallel input, and each is sampled at a defined instant during the reply. A free-running bit clock sets the timing. It is derived from the system clock divided by a fixed ratio, 64 by default. A reply always begins on a boundary of this bit clock, so the delay from the trigger to the first start bit depends on where the trigger falls within the bit period.

Each frame is eleven bit periods long. It holds a start bit, eight data bits sent least significant bit first, an even parity bit and a stop bit. The line is driven in inverted polarity, so that an external inverting driver can restore normal sense. The idle line is therefore low. The start bit is driven high, and every data and parity bit is driven as its complement. A busy output covers the whole reply. Trigger edges that arrive while busy is high are discarded.

Top module: `duo_frame_tx`

## Requirements
- R1: After reset, txOut is 0 and busy is 0.
- R2: A 0-to-1 change on send, seen at a clock edge while busy is 0, starts a reply, and busy reads 1 from the next cycle.
- R3: Let the phase of a cycle be the number of clock edges since reset release, modulo 64. If send is first seen high in a cycle of phase p with p below 32, the first start bit appears on txOut 64-p cycles later. Otherwise it appears 128-p cycles later. Before that point txOut stays 0.
- R4: Each frame lasts 11 bit periods of 64 cycles each, in this order: start (driven 1), eight data bits with bit 0 first (each driven as its complement), an even parity bit (driven as its complement, so the line carries the XNOR of the data bits), and a stop bit (driven 0).
- R5: The first frame's data is the value of idData in the clock cycle just before its start bit appears. Changes to idData after that cycle do not affect the reply.
- R6: The second frame's start bit follows the first frame's stop bit with no gap. Its data is the value of stData in the last cycle of its own start bit. Changes to stData before or after that cycle do not affect the reply.
- R7: busy stays 1 through the last cycle of the second stop bit and reads 0 in the cycle after it. txOut is 0 from then on.
- R8: Rising edges on send while busy is 1 have no effect. The reply on txOut is unchanged, and busy does not drop early.
- R9: txOut only changes in the first cycle of a bit period, which is a cycle of phase 0.
- R10: Holding send high after a reply does not start another reply. Only a new 0-to-1 change does.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; one bit period is 64 cycles |
| rst_n | input | 1 | Asynchronous active-low reset |
| send | input | 1 | Reply trigger, acts on its rising edge |
| idData | input | 8 | Identification byte for the first frame |
| stData | input | 8 | Status byte for the second frame |
| txOut | output | 1 | Serial output, inverted polarity, idle low |
| busy | output | 1 | High from the accepted trigger to the end of the second stop bit |

## Verification
The checker keeps its own phase count and assumes the bit clock starts at reset release with the default ratio of 64. It also assumes the output is built in the inverted polarity, so a low line means idle. The trigger and both data buses may change at any time. The stimulus changes them only on falling clock edges, so every value is stable at the sampling edge. It moves each data byte exactly one cycle before and one cycle after its capture edge, so the capture instant itself is tested. The triggers are placed at chosen phases, including the last cycle before a boundary and the last cycle of the first half period. Extra trigger edges are issued during the waiting time and inside both frames.

// File: rtl/duo_tx_pkg.sv
package duo_tx_pkg;

  // Strobes from the sequencer to the datapath, at most one group per cycle
  typedef struct packed {
    logic startBit;   // drive a start bit
    logic capId;      // with startBit: load the identification byte
    logic capSt;      // load the status byte and emit its bit 0
    logic shiftBit;   // emit the next queued bit
    logic goIdle;     // return the line to idle
  } txStrobe_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_SEND = 2'd2
  } txState_t;

endpackage

// File: rtl/duo_tx_baud.sv
module duo_tx_baud #(
  parameter int BIT_DIV = 64
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick,
  output logic firstHalf
);
  localparam int PH_W = (BIT_DIV > 1) ? $clog2(BIT_DIV) : 1;
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(BIT_DIV - 1);
  localparam logic [PH_W-1:0] PH_HALF = PH_W'(BIT_DIV / 2);

  logic [PH_W-1:0] phase;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= '0;
    end else if (phase == PH_LAST) begin
      phase <= '0;
    end else begin
      phase <= phase + 1'b1;
    end
  end

  assign tick      = (phase == PH_LAST);
  assign firstHalf = (phase < PH_HALF);
endmodule

// File: rtl/duo_tx_ctrl.sv
module duo_tx_ctrl
  import duo_tx_pkg::*;
#(
  parameter int FRAME_BITS = 11
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      send,
  input  logic      tick,
  input  logic      firstHalf,
  output logic      busy,
  output txStrobe_t stb
);
  localparam int IDX_W = $clog2(FRAME_BITS);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_BITS - 1);

  txState_t        state;
  logic            sendQ;
  logic            sendRise;
  logic [1:0]      waitCnt;
  logic [IDX_W-1:0] bitIdx;
  logic            frameSel;

  assign sendRise = send & ~sendQ;
  assign busy     = (state != ST_IDLE);

  always_comb begin
    stb = '0;
    case (state)
      ST_WAIT: begin
        if (tick && waitCnt == 2'd1) begin
          stb.startBit = 1'b1;
          stb.capId    = 1'b1;
        end
      end
      ST_SEND: begin
        if (tick) begin
          if (bitIdx == LAST_IDX) begin
            if (frameSel) stb.goIdle   = 1'b1;
            else          stb.startBit = 1'b1;
          end else if (frameSel && bitIdx == '0) begin
            stb.capSt = 1'b1;
          end else begin
            stb.shiftBit = 1'b1;
          end
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      sendQ    <= 1'b0;
      waitCnt  <= 2'd0;
      bitIdx   <= '0;
      frameSel <= 1'b0;
    end else begin
      sendQ <= send;
      case (state)
        ST_IDLE: begin
          if (sendRise) begin
            state <= ST_WAIT;
            // the boundary of this very cycle counts when it is the last phase
            waitCnt <= (tick || firstHalf) ? 2'd1 : 2'd2;
          end
        end
        ST_WAIT: begin
          if (tick) begin
            if (waitCnt == 2'd1) begin
              state    <= ST_SEND;
              bitIdx   <= '0;
              frameSel <= 1'b0;
            end else begin
              waitCnt <= waitCnt - 2'd1;
            end
          end
        end
        ST_SEND: begin
          if (tick) begin
            if (bitIdx == LAST_IDX) begin
              bitIdx <= '0;
              if (frameSel) state    <= ST_IDLE;
              else          frameSel <= 1'b1;
            end else begin
              bitIdx <= bitIdx + 1'b1;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/duo_tx_dp.sv
module duo_tx_dp
  import duo_tx_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter bit INVERT_OUT = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  txStrobe_t         stb,
  input  logic [DATA_W-1:0] idData,
  input  logic [DATA_W-1:0] stData,
  output logic              txOut
);
  // queued bits after the start bit: data, parity, stop (normal polarity)
  localparam int SR_W = DATA_W + 2;

  logic            lineN;
  logic [SR_W-1:0] sr;
  logic [SR_W-1:0] idVec;
  logic [SR_W-1:0] stVec;

  assign idVec = {1'b1, ^idData, idData};
  assign stVec = {1'b1, ^stData, stData};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lineN <= 1'b1;
      sr    <= '1;
    end else if (stb.startBit) begin
      lineN <= 1'b0;
      if (stb.capId) sr <= idVec;
    end else if (stb.capSt) begin
      lineN <= stVec[0];
      sr    <= {1'b1, stVec[SR_W-1:1]};
    end else if (stb.shiftBit) begin
      lineN <= sr[0];
      sr    <= {1'b1, sr[SR_W-1:1]};
    end else if (stb.goIdle) begin
      lineN <= 1'b1;
    end
  end

  generate
    if (INVERT_OUT) begin : g_inv
      assign txOut = ~lineN;
    end else begin : g_norm
      assign txOut = lineN;
    end
  endgenerate
endmodule

// File: rtl/duo_frame_tx.sv
module duo_frame_tx
  import duo_tx_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int BIT_DIV    = 64,
  parameter bit INVERT_OUT = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              send,
  input  logic [DATA_W-1:0] idData,
  input  logic [DATA_W-1:0] stData,
  output logic              txOut,
  output logic              busy
);
  localparam int FRAME_BITS = DATA_W + 3;

  logic      tick;
  logic      firstHalf;
  txStrobe_t stb;

  duo_tx_baud #(.BIT_DIV(BIT_DIV)) u_baud (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .firstHalf (firstHalf)
  );

  duo_tx_ctrl #(.FRAME_BITS(FRAME_BITS)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .send      (send),
    .tick      (tick),
    .firstHalf (firstHalf),
    .busy      (busy),
    .stb       (stb)
  );

  duo_tx_dp #(.DATA_W(DATA_W), .INVERT_OUT(INVERT_OUT)) u_dp (
    .clk    (clk),
    .rst_n  (rst_n),
    .stb    (stb),
    .idData (idData),
    .stData (stData),
    .txOut  (txOut)
  );
endmodule

// File: rtl/duo_frame_tx_chk.sv
module duo_frame_tx_chk #(
  parameter int BIT_DIV = 64
) (
  input logic clk,
  input logic rst_n,
  input logic send,
  input logic txOut,
  input logic busy
);
  localparam int CW = (BIT_DIV > 1) ? $clog2(BIT_DIV) : 1;
  localparam logic [CW-1:0] C_LAST = CW'(BIT_DIV - 1);

  logic [CW-1:0] ownPh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              ownPh <= '0;
    else if (ownPh == C_LAST) ownPh <= '0;
    else                     ownPh <= ownPh + 1'b1;
  end

  AST_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !txOut);  // R7

  AST_BUSY_ON_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(send) && !busy) |=> busy);  // R2

  AST_NO_START_AT_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !txOut);  // R3

  AST_BIT_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(txOut) |-> (ownPh == '0));  // R9

  AST_BUSY_HOLD_ON_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $rose(send) && ownPh != C_LAST) |=> busy);  // R8
endmodule

bind duo_frame_tx duo_frame_tx_chk #(.BIT_DIV(BIT_DIV)) u_chk (
  .clk   (clk),
  .rst_n (rst_n),
  .send  (send),
  .txOut (txOut),
  .busy  (busy)
);

// File: tb/sim_duo_frame_tx.sv
module sim_duo_frame_tx;
  localparam int CLK_PERIOD = 10;
  localparam int DIV        = 64;
  localparam int NBITS      = 22;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       send = 1'b0;
  logic [7:0] idData = 8'h00;
  logic [7:0] stData = 8'h00;
  wire        txOut;
  wire        busy;

  int unsigned cyc = 0;
  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  duo_frame_tx u0 (
    .clk    (clk),
    .rst_n  (rst_n),
    .send   (send),
    .idData (idData),
    .stData (stData),
    .txOut  (txOut),
    .busy   (busy)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) if (rst_n) cyc <= cyc + 1;

  task automatic chk(input logic got, input logic exp, input string what);
    nChecks++;
    if (got !== exp) begin
      nFails++;
      $display("FAIL %s: got %0b expected %0b", what, got, exp);
    end
  endtask

  task automatic waitPhase(input int p);
    do @(negedge clk); while (int'(cyc % DIV) != p);
  endtask

  // One full reply. idA/stA are presented early, idB/stB exactly at the
  // capture cycle, and their complements right after it.
  task automatic xmit(input int p, input logic [7:0] idA, input logic [7:0] idB,
                      input logic [7:0] stA, input logic [7:0] stB,
                      input bit extra, input bit hold, input string ctx);
    int   e;
    logic expBits [NBITS];
    string tag;
    bit   bad;
    e = (p < DIV/2) ? DIV - p : 2*DIV - p;
    for (int k = 0; k < NBITS; k++) begin
      int j;
      logic [7:0] d;
      j = k % 11;
      d = (k < 11) ? idB : stB;
      if (j == 0)       expBits[k] = 1'b1;
      else if (j <= 8)  expBits[k] = ~d[j-1];
      else if (j == 9)  expBits[k] = ~(^d);
      else              expBits[k] = 1'b0;
    end
    waitPhase(p);
    send = 1'b1; idData = idA; stData = stA;
    for (int n = 0; n <= e + NBITS*DIV; n++) begin
      if (n > 0) @(negedge clk);
      if (n == 2 && !hold) send = 1'b0;
      if (extra && !hold) begin
        if (n == 5 || n == e + 100 || n == e + 900) send = 1'b1;
        if (n == 7 || n == e + 102 || n == e + 902) send = 1'b0;
      end
      if (n == 1) chk(busy, 1'b1, {ctx, " R2 busy after accepted edge"});
      if (n == e - 1) begin
        chk(txOut, 1'b0, {ctx, " R3 line idle before start"});
        idData = idB;
      end
      if (n == e) begin
        chk(txOut, 1'b1, {ctx, " R3 start bit at expected cycle"});
        idData = ~idB;
      end
      if (n == e + 12*DIV - 1) stData = stB;
      if (n == e + 12*DIV)     stData = ~stB;
      if (n >= e && ((n - e) % DIV) == DIV/2) begin
        int k;
        int j;
        k = (n - e) / DIV;
        j = k % 11;
        if (j == 0 || j == 10) tag = "R4 start/stop";
        else if (j == 9)       tag = "R4 parity";
        else if (k < 11)       tag = "R5 id data";
        else                   tag = "R6 status data";
        if (extra) tag = {tag, " R8"};
        chk(txOut, expBits[k], $sformatf("%s %s bit %0d", ctx, tag, k));
        if (k == NBITS - 1) chk(busy, 1'b1, {ctx, " R7 busy during last stop"});
      end
      if (n == e + NBITS*DIV) begin
        chk(busy,  1'b0, {ctx, " R7 busy released"});
        chk(txOut, 1'b0, {ctx, " R7 line idle after reply"});
      end
    end
    if (hold) begin
      bad = 1'b0;
      repeat (200) begin
        @(negedge clk);
        if (busy || txOut) bad = 1'b1;
      end
      chk(bad, 1'b0, {ctx, " R10 held send does not retrigger"});
      send = 1'b0;
    end
    @(negedge clk);
  endtask

  task automatic testReset();
    chk(txOut, 1'b0, "R1 txOut in reset");
    chk(busy,  1'b0, "R1 busy in reset");
    rst_n = 1'b1;
    @(negedge clk);
    chk(txOut, 1'b0, "R1 txOut after reset");
    chk(busy,  1'b0, "R1 busy after reset");
  endtask

  task automatic testEarlyPhase();
    xmit(5, 8'h3C, 8'hA5, 8'h11, 8'h01, 1'b0, 1'b0, "early p5");
  endtask

  task automatic testLatePhase();
    xmit(40, 8'hFF, 8'h00, 8'h00, 8'hFF, 1'b0, 1'b0, "late p40");
  endtask

  task automatic testBoundaryPhases();
    xmit(31, 8'h00, 8'h80, 8'h55, 8'h7E, 1'b0, 1'b0, "edge p31");
    xmit(63, 8'h12, 8'hC3, 8'hAA, 8'h96, 1'b0, 1'b0, "edge p63");
    xmit(32, 8'h01, 8'hFE, 8'hF0, 8'h0F, 1'b0, 1'b0, "edge p32");
  endtask

  task automatic testBusyEdges();
    xmit(20, 8'h5A, 8'h69, 8'h33, 8'hE7, 1'b1, 1'b0, "busy-edges");
  endtask

  task automatic testHeldSend();
    xmit(50, 8'h77, 8'h4B, 8'h44, 8'hB2, 1'b0, 1'b1, "held-send");
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog R2: got no completion expected completion");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    testReset();
    testEarlyPhase();
    testLatePhase();
    testBoundaryPhases();
    testBusyEdges();
    testHeldSend();
    done = 1'b1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule